// File: doc/BRIEF.md
# Memory-Mapped Bidirectional Parallel Port

This block is a general-purpose parallel I/O peripheral that sits on a simple processor bus as a slave. Each of its pins is set to drive or to sense through its own direction bit. Input pins are brought into the clock domain by a two-stage synchroniser. Their rising edges are held in a sticky capture register, and a mask register chooses which captured edges raise the single interrupt line. Software clears a captured edge by writing a 1 to its bit.

The pin side has three parts: an output value, a per-bit output enable and the sensed input value. A pad cell outside the block joins them. The parameter `MODE` picks one of three variants. The bidirectional variant has every register. The input-only variant has no direction register and no output drive. The output-only variant has no input path, no mask register and no edge capture. `WIDTH` sets the number of pins, from 1 to 32.

The bus uses a byte address. Bits [3:2] of `bus_addr` choose the register and bits [1:0] must be zero. A read returns data in the same cycle as `bus_rd`. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `gpio_port`

## Requirements
- R1: Address decode: offset 0x0 selects the data register, 0x4 the direction register, 0x8 the interrupt mask and 0xC the edge-capture register. Any offset whose bits [1:0] are not zero is unmapped: a read of it returns 0 and a write to it changes nothing.
- R2: After reset, `pin_oe` and `pin_out` are 0, the mask and edge-capture registers read 0, and `irq` is low.
- R3: In the bidirectional variant (`MODE`=0), a 1 in direction bit i makes pin i an output and a 0 makes it an input. `pin_oe` follows the direction register, and the direction register reads back as written.
- R4: A write to the data register sets `pin_out` from the next cycle. A read of the data register returns `pin_in` as it was sampled two clock edges earlier.
- R5: Register bits at and above `WIDTH` read as 0, and writes to them are ignored.
- R6: A rising edge on a pin whose direction bit is 0 sets its edge-capture bit one edge after the new value reaches the data register. Falling edges never set a capture bit. Edges on output pins never set a capture bit.
- R7: Writing a 1 to an edge-capture bit clears it, and writing a 0 leaves it unchanged. If a rising edge arrives on the same clock edge as the clearing write, the bit stays set.
- R8: `irq` is high exactly when some bit is set in both the edge-capture register and the mask register.
- R9: In the input-only variant (`MODE`=1), `pin_oe` stays 0. Writes to the data and direction registers have no effect, and the direction register reads 0.
- R10: In the output-only variant (`MODE`=2), `pin_oe` is all ones and `pin_out` follows the data register. The data, mask and edge-capture registers read 0, and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 4 | Byte offset of the register being accessed |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read is in progress |
| pin_in | input | WIDTH | Value sensed at the pins |
| pin_out | output | WIDTH | Value driven on pins that are outputs |
| pin_oe | output | WIDTH | Per-pin output enable (1 = drive) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a rising edge that arrives on the same clock edge as a write that clears the same capture bit. The stimulus changes the pin at a falling clock edge. It then waits exactly two rising edges so that the edge detector is active, and only then issues the clearing write. The bit is expected to read back as 1, and a second write must clear it. Edges on pins set as outputs, and falling edges, are also driven on purpose, so that only the qualifying edges are seen to set capture bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  localparam int MODE_BIDIR = 0;
  localparam int MODE_IN    = 1;
  localparam int MODE_OUT   = 2;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_EDGE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage0_q, stage1_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_n_out = stage1_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int W       = 32,
  parameter bit HAS_OUT = 1'b1,
  parameter bit HAS_DIR = 1'b1,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] mask_q
);
  generate
    if (HAS_OUT) begin : g_out
      logic [W-1:0] out_d;
      always_comb begin
        out_d = out_q;
        if (data_we) out_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
      end
    end else begin : g_no_out
      assign out_q = '0;
    end

    if (HAS_DIR) begin : g_dir
      logic [W-1:0] dir_d;
      always_comb begin
        dir_d = dir_q;
        if (dir_we) dir_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
      end
    end else begin : g_fixed_dir
      assign dir_q = HAS_OUT ? {W{1'b1}} : {W{1'b0}};
    end

    if (HAS_IRQ) begin : g_mask
      logic [W-1:0] mask_d;
      always_comb begin
        mask_d = mask_q;
        if (mask_we) mask_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
      end
    end else begin : g_no_mask
      assign mask_q = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] dir_q,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] cap_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  assign rise = pin_s & ~prev_q & ~dir_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_d, bit_q;
      always_comb begin
        bit_d = bit_q;
        if (clr_we && clr_bits[i]) bit_d = 1'b0;
        if (rise[i])               bit_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign cap_q[i] = bit_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int MODE  = MODE_BIDIR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_in,
  output logic [WIDTH-1:0]   pin_out,
  output logic [WIDTH-1:0]   pin_oe,
  output logic               irq
);
  localparam bit HAS_IN  = (MODE != MODE_OUT);
  localparam bit HAS_OUT = (MODE != MODE_IN);
  localparam bit HAS_DIR = (MODE == MODE_BIDIR);

  logic             rst_n_i;
  logic             aligned;
  reg_sel_e         sel;
  logic             wr_hit;
  logic [WIDTH-1:0] wdata_n;
  logic [WIDTH-1:0] pin_s, out_q, dir_q, mask_q, cap_q;
  logic [BUS_W-1:0] rd_word;

  function automatic logic [BUS_W-1:0] widen(input logic [WIDTH-1:0] v);
    logic [BUS_W-1:0] w;
    w = '0;
    w[WIDTH-1:0] = v;
    return w;
  endfunction

  gpio_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign wr_hit  = bus_wr && aligned;
  assign wdata_n = bus_wdata[WIDTH-1:0];

  gpio_ctrl_regs #(
    .W       (WIDTH),
    .HAS_OUT (HAS_OUT),
    .HAS_DIR (HAS_DIR),
    .HAS_IRQ (HAS_IN)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .data_we (wr_hit && sel == SEL_DATA),
    .dir_we  (wr_hit && sel == SEL_DIR),
    .mask_we (wr_hit && sel == SEL_MASK),
    .wdata   (wdata_n),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .mask_q  (mask_q)
  );

  generate
    if (HAS_IN) begin : g_in
      gpio_sync #(.W(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n_i),
        .d     (pin_in),
        .q     (pin_s)
      );
      gpio_edge_cap #(.W(WIDTH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n_i),
        .pin_s    (pin_s),
        .dir_q    (dir_q),
        .clr_we   (wr_hit && sel == SEL_EDGE),
        .clr_bits (wdata_n),
        .cap_q    (cap_q)
      );
    end else begin : g_no_in
      assign pin_s = '0;
      assign cap_q = '0;
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      unique case (sel)
        SEL_DATA: rd_word = widen(pin_s);
        SEL_DIR:  rd_word = HAS_DIR ? widen(dir_q) : '0;
        SEL_MASK: rd_word = widen(mask_q);
        SEL_EDGE: rd_word = widen(cap_q);
        default:  rd_word = '0;
      endcase
    end
  end

  assign bus_rdata = bus_rd ? rd_word : '0;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign irq       = |(cap_q & mask_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 32,
  parameter int MODE  = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             irq
);
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0));

  p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 4'h4) |=> $stable(pin_oe));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 4'h0) |=> $stable(pin_out));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && (bus_addr == 4'h8 || bus_addr == 4'hC))) |=> irq);

  p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h8 && bus_wdata == 32'd0) |=> !irq);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 12;
  localparam int WI = 4;
  localparam int WO = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic        wr_b, wr_i, wr_o;
  logic [31:0] rdata_b, rdata_i, rdata_o;
  logic [WB-1:0] pin_in_b, pin_out_b, pin_oe_b;
  logic [WI-1:0] pin_in_i, pin_out_i, pin_oe_i;
  logic [WO-1:0] pin_in_o, pin_out_o, pin_oe_o;
  logic irq_b, irq_i, irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.WIDTH(WB), .MODE(0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(wr_b),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin_in_b),
    .pin_out(pin_out_b), .pin_oe(pin_oe_b), .irq(irq_b));

  gpio_port #(.WIDTH(WI), .MODE(1)) u_in (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(wr_i),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_i), .pin_in(pin_in_i),
    .pin_out(pin_out_i), .pin_oe(pin_oe_i), .irq(irq_i));

  gpio_port #(.WIDTH(WO), .MODE(2)) u_out (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(wr_o),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_o), .pin_in(pin_in_o),
    .pin_out(pin_out_o), .pin_oe(pin_oe_o), .irq(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // which: 0 = dut, 1 = u_in, 2 = u_out
  task automatic bus_write(input int which, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    wr_b = (which == 0);
    wr_i = (which == 1);
    wr_o = (which == 2);
    @(negedge clk);
    wr_b = 1'b0; wr_i = 1'b0; wr_o = 1'b0;
  endtask

  task automatic bus_read(input int which, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1;
    d = (which == 0) ? rdata_b : (which == 1) ? rdata_i : rdata_o;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R2 pin_oe after reset", 32'(pin_oe_b), 32'h0);
    chk("R2 pin_out after reset", 32'(pin_out_b), 32'h0);
    chk("R2 irq after reset", 32'(irq_b), 32'h0);
    bus_read(0, 4'h4, v); chk("R2 direction after reset", v, 32'h0);
    bus_read(0, 4'h8, v); chk("R2 mask after reset", v, 32'h0);
    bus_read(0, 4'hC, v); chk("R2 edge capture after reset", v, 32'h0);
  endtask

  task automatic t_direction;
    logic [31:0] v;
    bus_write(0, 4'h4, 32'h0F0);
    chk("R3 pin_oe follows direction", 32'(pin_oe_b), 32'h0F0);
    bus_read(0, 4'h4, v); chk("R3 direction readback", v, 32'h0F0);
  endtask

  task automatic t_data_and_edges;
    logic [31:0] v;
    bus_write(0, 4'h0, 32'hA5C);
    chk("R4 pin_out after data write", 32'(pin_out_b), 32'hA5C);
    @(negedge clk); pin_in_b = 12'h3C3;
    bus_read(0, 4'h0, v); chk("R4 data read one edge after pin change", v, 32'h0);
    bus_read(0, 4'h0, v); chk("R4 data read two edges after pin change", v, 32'h3C3);
    bus_read(0, 4'hC, v); chk("R6 rising edges captured on input pins only", v, 32'h303);
    bus_write(0, 4'hC, 32'h001);
    bus_read(0, 4'hC, v); chk("R7 W1C clears only written bits", v, 32'h302);
    bus_write(0, 4'hC, 32'hFFF);
    bus_read(0, 4'hC, v); chk("R7 W1C clears all", v, 32'h0);
    @(negedge clk); pin_in_b = 12'h000;
    repeat (3) @(negedge clk);
    bus_read(0, 4'hC, v); chk("R6 falling edges not captured", v, 32'h0);
    @(negedge clk); pin_in_b = 12'h011;
    repeat (3) @(negedge clk);
    bus_read(0, 4'hC, v); chk("R6 output pin edge ignored, input pin edge kept", v, 32'h001);
  endtask

  task automatic t_irq;
    chk("R8 irq low with mask clear", 32'(irq_b), 32'h0);
    bus_write(0, 4'h8, 32'h001);
    chk("R8 irq high when masked bit captured", 32'(irq_b), 32'h1);
    bus_write(0, 4'h8, 32'h002);
    chk("R8 irq low when mask misses capture", 32'(irq_b), 32'h0);
    bus_write(0, 4'h8, 32'h001);
    bus_write(0, 4'hC, 32'h001);
    chk("R8 irq low after capture cleared", 32'(irq_b), 32'h0);
  endtask

  task automatic t_set_beats_clear;
    logic [31:0] v;
    @(negedge clk); pin_in_b = 12'h013;
    @(negedge clk);
    bus_write(0, 4'hC, 32'h002);
    bus_read(0, 4'hC, v); chk("R7 edge wins over same-cycle clear", v, 32'h002);
    bus_write(0, 4'hC, 32'h002);
    bus_read(0, 4'hC, v); chk("R7 later clear succeeds", v, 32'h0);
  endtask

  task automatic t_upper_and_unmapped;
    logic [31:0] v;
    bus_write(0, 4'h4, 32'hFFFF_F0F0);
    bus_read(0, 4'h4, v); chk("R5 upper direction bits read zero", v, 32'h0F0);
    bus_write(0, 4'h8, 32'hFFFF_FFFF);
    bus_read(0, 4'h8, v); chk("R5 upper mask bits read zero", v, 32'hFFF);
    bus_write(0, 4'h8, 32'h0);
    bus_write(0, 4'h5, 32'hFFF);
    bus_read(0, 4'h4, v); chk("R1 unmapped write leaves direction", v, 32'h0F0);
    bus_read(0, 4'h2, v); chk("R1 unmapped read is zero", v, 32'h0);
    bus_read(0, 4'h0, v); chk("R1 offset 0x0 is data", v, 32'h013);
  endtask

  task automatic t_input_only;
    logic [31:0] v;
    bus_write(1, 4'h0, 32'hF);
    bus_write(1, 4'h4, 32'hF);
    chk("R9 input-only pin_oe stays zero", 32'(pin_oe_i), 32'h0);
    chk("R9 input-only data write ignored", 32'(pin_out_i), 32'h0);
    bus_read(1, 4'h4, v); chk("R9 input-only direction reads zero", v, 32'h0);
    @(negedge clk); pin_in_i = 4'h5;
    repeat (3) @(negedge clk);
    bus_read(1, 4'h0, v); chk("R9 input-only data read", v, 32'h5);
    bus_read(1, 4'hC, v); chk("R9 input-only edge capture", v, 32'h5);
    bus_write(1, 4'h8, 32'h4);
    chk("R9 input-only irq", 32'(irq_i), 32'h1);
  endtask

  task automatic t_output_only;
    logic [31:0] v;
    chk("R10 output-only pin_oe all ones", 32'(pin_oe_o), 32'h3FF);
    bus_write(2, 4'h0, 32'h2AB);
    chk("R10 output-only pin_out", 32'(pin_out_o), 32'h2AB);
    @(negedge clk); pin_in_o = 10'h3FF;
    repeat (3) @(negedge clk);
    bus_read(2, 4'h0, v); chk("R10 output-only data reads zero", v, 32'h0);
    bus_write(2, 4'h8, 32'hFFF);
    bus_read(2, 4'h8, v); chk("R10 output-only mask reads zero", v, 32'h0);
    bus_read(2, 4'hC, v); chk("R10 output-only edge reads zero", v, 32'h0);
    chk("R10 output-only irq low", 32'(irq_o), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = 4'h0; bus_rd = 1'b0; bus_wdata = 32'h0;
    wr_b = 1'b0; wr_i = 1'b0; wr_o = 1'b0;
    pin_in_b = '0; pin_in_i = '0; pin_in_o = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_direction();
    t_data_and_edges();
    t_irq();
    t_set_beats_clear();
    t_upper_and_unmapped();
    t_input_only();
    t_output_only();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule